// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is a serial peripheral (slave) that sits inside programmable logic and accepts 16-bit command frames from a host controller. A frame travels most significant bit first. Its top four bits are an opcode and its lower twelve bits are an argument. The opcode decides which internal register the argument updates. Two registers are held: a 12-bit mode word that steers the rest of the logic, and a single trace-enable flag.

The serial clock, data and active-low select are brought into the system clock domain through two-flop synchronizers, and edges are detected there. A frame counts only if the select is released after exactly sixteen bits were sampled. Any other length is dropped without effect. Unknown opcodes are dropped too. The serial clock must be slow enough that each of its phases spans at least two system clock cycles.

The decoded outputs are plain level signals with no handshake. A value written by a frame appears a fixed few cycles after the select is released, and it holds until a later valid frame changes it.

Top module: `spicmd_rx`

## Requirements
- R1: After reset `mode_word` is 0 and `trace_en` is 0.
- R2: A frame is shifted in most significant bit first. Bits 15..12 are the opcode and bits 11..0 are the argument.
- R3: `spi_mosi` is sampled on each rising edge of `spi_sck` while `spi_csn` is low. The clock idles low.
- R4: Opcode 4'h1 writes the 12-bit argument into `mode_word`.
- R5: Opcode 4'h2 sets `trace_en` to argument bit 0 (1 enables, 0 disables) and leaves `mode_word` unchanged.
- R6: A frame with fewer than 16 sampled bits changes no output.
- R7: A frame with more than 16 sampled bits changes no output. The bit counter saturates and does not wrap.
- R8: A 16-bit frame with any opcode other than 4'h1 or 4'h2 changes no output.
- R9: Outputs change only when `spi_csn` is released. They stay unchanged while a frame is in progress, and a valid frame's effect is visible within 6 system clocks of the release.
- R10: Rising edges of `spi_sck` while `spi_csn` is high are not sampled and do not affect the next frame.
- R11: A rising `spi_sck` edge that reaches the block in the same cycle as the `spi_csn` release is counted as a bit of the closing frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_csn | input | 1 | Active-low frame select |
| mode_word | output | 12 | Mode/configuration register |
| trace_en | output | 1 | Trace enable flag |

## Verification
Two functions can fall in the same system cycle: capturing the last data bit and closing the frame on select release. The bench provokes this by raising `spi_sck` and `spi_csn` on the same clock, so that both pass through identical synchronizer depth and arrive together. It judges the result by whether a 16-bit frame sent this way is accepted with its final bit intact. Similar frames that also change the least significant argument bit show that the bit was taken and not lost or duplicated.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;
  localparam int FRAME_W = 16;
  localparam int OP_W    = 4;
  localparam int ARG_W   = FRAME_W - OP_W;
  localparam int SYNC_STAGES = 2;

  localparam logic [OP_W-1:0] OP_SET_MODE  = 4'h1;
  localparam logic [OP_W-1:0] OP_SET_TRACE = 4'h2;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [ARG_W-1:0] arg;
  } cmd_word_t;
endpackage

// File: rtl/spicmd_sync.sv
module spicmd_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
        else        chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spicmd_capture.sv
module spicmd_capture
  import spicmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sck_s,
  input  logic      mosi_s,
  input  logic      csn_s,
  output logic      frame_ok,
  output cmd_word_t frame_word
);
  localparam int CNT_MAX_I = FRAME_W + 1;
  localparam int CNT_W = $clog2(CNT_MAX_I + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(CNT_MAX_I);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               p_sck, p_csn;
  logic [FRAME_W-1:0] shreg, sh_nxt;
  logic [CNT_W-1:0]   cnt, cnt_nxt;
  logic               take, csn_rise, csn_fall;

  always_comb begin
    // sample while the select was active in the prior cycle, so a clock edge
    // arriving together with the release still counts
    take     = sck_s & ~p_sck & ~p_csn;
    csn_rise = csn_s & ~p_csn;
    csn_fall = ~csn_s & p_csn;
    sh_nxt   = take ? {shreg[FRAME_W-2:0], mosi_s} : shreg;
    cnt_nxt  = (take && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sck <= 1'b0;
      p_csn <= 1'b1;
      shreg <= '0;
      cnt   <= '0;
    end else begin
      p_sck <= sck_s;
      p_csn <= csn_s;
      if (csn_fall) begin
        shreg <= '0;
        cnt   <= '0;
      end else begin
        shreg <= sh_nxt;
        cnt   <= cnt_nxt;
      end
    end
  end

  assign frame_ok   = csn_rise && (cnt_nxt == CNT_FULL);
  assign frame_word = cmd_word_t'(sh_nxt);

  // R7: the counter saturates and never wraps back into range
  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);
  // R10: while the select is idle nothing is shifted
  a_r10_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (p_csn && csn_s) |=> ($stable(shreg) && $stable(cnt)));
  // R3: at most one bit per system cycle
  a_r3_one_bit_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn_fall) |=> ((cnt - $past(cnt)) <= 1));
endmodule

// File: rtl/spicmd_decode.sv
module spicmd_decode
  import spicmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_ok,
  input  cmd_word_t        frame_word,
  output logic [ARG_W-1:0] mode_q,
  output logic             trace_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      trace_q <= 1'b0;
    end else if (frame_ok) begin
      case (frame_word.op)
        OP_SET_MODE:  mode_q  <= frame_word.arg;
        OP_SET_TRACE: trace_q <= frame_word.arg[0];
        default: ;
      endcase
    end
  end

  // R4
  a_r4_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && frame_word.op == OP_SET_MODE) |=> (mode_q == $past(frame_word.arg)));
  // R5
  a_r5_trace_write: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && frame_word.op == OP_SET_TRACE) |=> (trace_q == $past(frame_word.arg[0]) && $stable(mode_q)));
  // R8
  a_r8_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && frame_word.op != OP_SET_MODE && frame_word.op != OP_SET_TRACE)
      |=> ($stable(mode_q) && $stable(trace_q)));
  // R9
  a_r9_hold_without_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_ok) |=> ($stable(mode_q) && $stable(trace_q)));
endmodule

// File: rtl/spicmd_rx.sv
module spicmd_rx
  import spicmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  input  logic             spi_csn,
  output logic [ARG_W-1:0] mode_word,
  output logic             trace_en
);
  logic [2:0] raw, synced;
  logic       frame_ok;
  cmd_word_t  frame_word;

  assign raw = {spi_csn, spi_mosi, spi_sck};

  spicmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced));

  spicmd_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .sck_s(synced[0]), .mosi_s(synced[1]), .csn_s(synced[2]),
    .frame_ok(frame_ok), .frame_word(frame_word));

  spicmd_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .frame_ok(frame_ok), .frame_word(frame_word),
    .mode_q(mode_word), .trace_q(trace_en));

  // R9: a frame only commits when the synchronized select reads released
  a_r9_commit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> synced[2]);
endmodule

// File: tb/spicmd_rx_test.sv
module spicmd_rx_test;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic [11:0] mode_word;
  logic        trace_en;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [11:0] exp_mode = '0;
  logic        exp_tr = 1'b0;

  always #4 clk = ~clk;

  spicmd_rx uut (.clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi),
                 .spi_csn(csn), .mode_word(mode_word), .trace_en(trace_en));

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    check(mode_word == exp_mode, req, {4'h0, mode_word}, {4'h0, exp_mode});
    check(trace_en == exp_tr, req, {15'h0, trace_en}, {15'h0, exp_tr});
  endtask

  function automatic void model(input logic [15:0] w, input int n);
    if (n == 16) begin
      if (w[15:12] == 4'h1) exp_mode = w[11:0];
      else if (w[15:12] == 4'h2) exp_tr = w[0];
    end
  endfunction

  task automatic cs_low();
    csn = 1'b0; waitc(HALF);
  endtask

  task automatic shift_bit(input logic b, input bit with_release);
    mosi = b; waitc(HALF);
    sck = 1'b1;
    if (with_release) csn = 1'b1;
    waitc(HALF);
    sck = 1'b0;
  endtask

  // n bits: first min(n,16) from the word MSB first, extra bits are ones
  task automatic send(input logic [15:0] w, input int n, input bit coincide);
    cs_low();
    for (int i = 0; i < n; i++)
      shift_bit((i < 16) ? w[15-i] : 1'b1, coincide && (i == n-1));
    if (!coincide) begin
      waitc(HALF); csn = 1'b1;
    end
    waitc(8);
    model(w, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    waitc(4); rst_n = 1'b1; waitc(4);
    check_outs("R1 reset");

    send(16'h1A5C, 16, 0); check_outs("R4 R2 mode write");
    send(16'h2001, 16, 0); check_outs("R5 trace on");
    check(mode_word == 12'hA5C, "R5 mode kept", {4'h0, mode_word}, 16'h0A5C);
    send(16'h2FFE, 16, 0); check_outs("R5 trace off via bit0");
    send(16'h1123, 15, 0); check_outs("R6 short frame");
    send(16'h1456, 17, 0); check_outs("R7 long frame");
    send(16'h1789, 40, 0); check_outs("R7 saturating long frame");
    send(16'h0FFF, 16, 0); check_outs("R8 opcode 0");
    send(16'hF321, 16, 0); check_outs("R8 opcode F");

    // R9: mid-frame outputs unchanged
    cs_low();
    for (int i = 0; i < 16; i++) shift_bit(((16'h1F0F >> (15 - i)) & 16'h1) != 0, 1'b0);
    waitc(10);
    check_outs("R9 no change before release");
    csn = 1'b1; waitc(6);
    model(16'h1F0F, 16);
    check_outs("R9 commit after release");

    // R10: clock edges with select idle
    mosi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sck = 1'b1; waitc(HALF); sck = 1'b0; waitc(HALF);
    end
    check_outs("R10 idle edges no effect");
    send(16'h1234, 16, 0); check_outs("R10 R3 frame after idle edges");

    // R11: last edge coincides with release
    send(16'h1ABD, 16, 1); check_outs("R11 coincident last edge");
    send(16'h1ABC, 16, 1); check_outs("R11 coincident bit0 zero");
    send(16'h2001, 16, 1); check_outs("R11 coincident trace");

    for (int k = 0; k < 50; k++) begin
      logic [15:0] w;
      int n, sel;
      w = 16'($urandom);
      sel = int'($urandom_range(0, 9));
      if (sel < 4) w[15:12] = 4'h1;
      else if (sel < 7) w[15:12] = 4'h2;
      n = 16;
      sel = int'($urandom_range(0, 9));
      if (sel == 0) n = int'($urandom_range(1, 15));
      else if (sel == 1) n = int'($urandom_range(17, 24));
      send(w, n, ($urandom_range(0, 3) == 0));
      check_outs("R2 R4 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule